// File: doc/BRIEF.md
# Bit-Sliced Four-Function ALU

This block is a purely combinational arithmetic/logic unit for a simple processor datapath. It takes two operands of a parameterised width and a two-bit function code. It returns the selected result, a signed overflow flag and a flag that is high whenever the result holds at least one set bit. A branch-on-equal path can use that last flag directly after a subtraction.

The datapath is a column of identical one-bit cells. Each cell holds a full adder, an AND gate, an OR gate and a small selector. Carries ripple upward from bit 0. Subtraction uses the same adders: one control line complements every bit of the second operand as it enters the cells, and the same line feeds the carry into bit 0. The carry out of the top cell is used only to form the overflow flag and does not leave the block.

Top module: `alu_bitslice`

## Requirements
- R1: With `func` = 2'b00, `result` equals `opd_a + opd_b` modulo 2^WIDTH.
- R2: With `func` = 2'b01, `result` equals `opd_a - opd_b` modulo 2^WIDTH, i.e. `opd_a + ~opd_b + 1`.
- R3: With `func` = 2'b10, `result` equals the bitwise OR of the operands.
- R4: With `func` = 2'b11, `result` equals the bitwise AND of the operands.
- R5: With `func` = 2'b00, `ovf` is 1 exactly when the true signed (two's complement) sum of the operands lies outside the signed WIDTH-bit range.
- R6: With `func` = 2'b01, `ovf` is 1 exactly when the true signed difference `opd_a - opd_b` lies outside the signed WIDTH-bit range.
- R7: With `func` = 2'b10 or 2'b11, `ovf` is 0 for all operands.
- R8: `nonzero` is 1 exactly when `result` has at least one bit set, for every function code.
- R9: All outputs are combinational: they follow an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | WIDTH | First operand |
| opd_b | input | WIDTH | Second operand (subtrahend for subtract) |
| func | input | 2 | Function code: 00 add, 01 subtract, 10 OR, 11 AND |
| result | output | WIDTH | Selected result |
| ovf | output | 1 | Signed overflow for add/subtract, 0 otherwise |
| nonzero | output | 1 | High when `result` is not all zeros |

## Verification
The bound checker tests every settled input combination against whole-word formulations. It checks the result of each function code, overflow through operand and result sign bits rather than through carries, overflow being held low for the logic functions, and the non-zero flag against the result. The bench's scenarios are what show that the corner operands are reached: zero, all ones, the most negative and the most positive values, paired under each function. They also show the combinational timing of R9, because the bench changes inputs and samples half a period later with no edge in between. The expected values there come from a reference that uses wide signed integer arithmetic.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      FN_ADD = 2'b00,
      FN_SUB = 2'b01,
      FN_OR  = 2'b10,
      FN_AND = 2'b11
   } alu_fn_e;
endpackage

// File: rtl/alu_cell.sv
// One bit of the ALU: full adder on (a, b^inv, ci), plus AND/OR, with a 4:1 pick.
module alu_cell
   import alu_pkg::*;
(
   input  logic    a,
   input  logic    b,
   input  logic    inv,
   input  logic    ci,
   input  alu_fn_e fn,
   output logic    q,
   output logic    co
);
   logic bx;
   logic sum;

   always_comb begin
      bx  = b ^ inv;
      sum = a ^ bx ^ ci;
      co  = (a & bx) | (a & ci) | (bx & ci);
      unique case (fn)
         FN_ADD, FN_SUB: q = sum;
         FN_OR:          q = a | b;
         FN_AND:         q = a & b;
         default:        q = sum;
      endcase
   end
endmodule

// File: rtl/alu_nz_detect.sv
// Non-zero detector; GROUP selects a flat reduction or a two-level grouped OR.
module alu_nz_detect #(
   parameter int WIDTH = 32,
   parameter int GROUP = 8
) (
   input  logic [WIDTH-1:0] vec,
   output logic             any_set
);
   localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;

   initial begin
      if (GROUP < 1) $error("alu_nz_detect: GROUP must be at least 1");
   end

   generate
      if (GROUP >= WIDTH) begin : g_flat
         assign any_set = |vec;
      end else begin : g_grouped
         logic [NGRP-1:0] part;
         for (genvar g = 0; g < NGRP; g++) begin : g_part
            localparam int LO = g * GROUP;
            localparam int HI = ((g + 1) * GROUP > WIDTH) ? WIDTH - 1 : (g + 1) * GROUP - 1;
            assign part[g] = |vec[HI:LO];
         end
         assign any_set = |part;
      end
   endgenerate
endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
   import alu_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int NZ_GROUP = 8
) (
   input  logic [WIDTH-1:0] opd_a,
   input  logic [WIDTH-1:0] opd_b,
   input  logic [1:0]       func,
   output logic [WIDTH-1:0] result,
   output logic             ovf,
   output logic             nonzero
);
   localparam int MSB = WIDTH - 1;

   initial begin
      if (WIDTH < 2) $error("alu_bitslice: WIDTH must be at least 2");
   end

   alu_fn_e fn;
   logic    sub_en;
   logic    arith;
   logic    top_ci;
   logic    top_co;

   assign fn     = alu_fn_e'(func);
   assign sub_en = (fn == FN_SUB);
   assign arith  = (fn == FN_ADD) | (fn == FN_SUB);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_slice
         logic ci;
         logic co;
         if (i == 0) begin : g_first
            assign ci = sub_en;
         end else begin : g_next
            assign ci = g_slice[i-1].co;
         end
         alu_cell u_cell (
            .a   (opd_a[i]),
            .b   (opd_b[i]),
            .inv (sub_en),
            .ci  (ci),
            .fn  (fn),
            .q   (result[i]),
            .co  (co)
         );
      end
   endgenerate

   assign top_ci = g_slice[MSB].ci;
   assign top_co = g_slice[MSB].co;
   assign ovf    = arith & (top_ci ^ top_co);

   alu_nz_detect #(
      .WIDTH (WIDTH),
      .GROUP (NZ_GROUP)
   ) u_nz (
      .vec     (result),
      .any_set (nonzero)
   );
endmodule

// File: rtl/alu_bitslice_chk.sv
module alu_bitslice_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opd_a,
   input logic [WIDTH-1:0] opd_b,
   input logic [1:0]       func,
   input logic [WIDTH-1:0] result,
   input logic             ovf,
   input logic             nonzero
);
   localparam int MSB = WIDTH - 1;

   logic sa, sb, sr;
   assign sa = opd_a[MSB];
   assign sb = opd_b[MSB];
   assign sr = result[MSB];

   always_comb begin
      if (func == 2'b00) begin
         assert_add_R1: assert (result == opd_a + opd_b)
            else $error("R1 add mismatch");
         assert_add_ovf_R5: assert (ovf == ((sa == sb) && (sr != sa)))
            else $error("R5 add overflow mismatch");
      end
      if (func == 2'b01) begin
         assert_sub_R2: assert (result == opd_a - opd_b)
            else $error("R2 sub mismatch");
         assert_sub_ovf_R6: assert (ovf == ((sa != sb) && (sr != sa)))
            else $error("R6 sub overflow mismatch");
      end
      if (func == 2'b10) begin
         assert_or_R3: assert (result == (opd_a | opd_b))
            else $error("R3 or mismatch");
      end
      if (func == 2'b11) begin
         assert_and_R4: assert (result == (opd_a & opd_b))
            else $error("R4 and mismatch");
      end
      if (func[1]) begin
         assert_no_overflow_R7: assert (!ovf)
            else $error("R7 overflow on logic op");
      end
      assert_nonzero_R8: assert (nonzero == (result != '0))
         else $error("R8 nonzero mismatch");
   end
endmodule

bind alu_bitslice alu_bitslice_chk #(.WIDTH(WIDTH)) u_chk (
   .opd_a   (opd_a),
   .opd_b   (opd_b),
   .func    (func),
   .result  (result),
   .ovf     (ovf),
   .nonzero (nonzero)
);

// File: tb/alu_bitslice_tb.sv
module alu_bitslice_tb;
   localparam int  W        = 32;
   localparam time CLK_PER  = 10ns;
   localparam int  WATCHDOG = 20000;

   logic         clk = 1'b0;
   logic [W-1:0] a, b;
   logic [1:0]   fn;
   logic [W-1:0] y;
   logic         ov, nz;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   always #(CLK_PER/2) clk = ~clk;

   alu_bitslice #(.WIDTH(W)) u_dut (
      .opd_a(a), .opd_b(b), .func(fn),
      .result(y), .ovf(ov), .nonzero(nz)
   );

   // Behavioural reference: wide signed integers
   function automatic void ref_model(input logic [W-1:0] ra, input logic [W-1:0] rb,
                                     input logic [1:0] rf,
                                     output logic [W-1:0] ry, output logic rov);
      longint sa, sb, full;
      sa = longint'($signed(ra));
      sb = longint'($signed(rb));
      rov = 1'b0;
      case (rf)
         2'd0: full = sa + sb;
         2'd1: full = sa - sb;
         2'd2: full = longint'(ra | rb);
         default: full = longint'(ra & rb);
      endcase
      ry = full[W-1:0];
      if (rf < 2)
         rov = (full > ((64'sd1 <<< (W-1)) - 1)) || (full < -(64'sd1 <<< (W-1)));
   endfunction

   task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   // Drive on posedge, sample at the following negedge (R9: no edge needed).
   task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic [1:0] tf);
      logic [W-1:0] ey;
      logic         eov;
      @(posedge clk);
      a = ta; b = tb; fn = tf;
      ref_model(ta, tb, tf, ey, eov);
      @(negedge clk);
      case (tf)
         2'd0: begin check("R1 add", y, ey);  check("R5 add ovf", W'(ov), W'(eov)); end
         2'd1: begin check("R2 sub", y, ey);  check("R6 sub ovf", W'(ov), W'(eov)); end
         2'd2: begin check("R3 or", y, ey);   check("R7 ovf low", W'(ov), '0); end
         default: begin check("R4 and", y, ey); check("R7 ovf low", W'(ov), '0); end
      endcase
      check("R8 nonzero", W'(nz), W'(ey != '0));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] corner [5];
      a = '0; b = '0; fn = 2'd0;
      corner[0] = '0;
      corner[1] = '1;
      corner[2] = {1'b1, {(W-1){1'b0}}};
      corner[3] = {1'b0, {(W-1){1'b1}}};
      corner[4] = W'(1);

      // Idle state: 0 + 0 gives zero, no overflow, nonzero low
      @(negedge clk);
      check("R1 idle result", y, '0);
      check("R8 idle nonzero", W'(nz), '0);
      check("R5 idle ovf", W'(ov), '0);

      // Directed overflow cases
      apply(corner[3], corner[4], 2'd0);  // max + 1 overflows (R5)
      check("R5 max+1 ovf", W'(ov), W'(1));
      apply(corner[2], corner[4], 2'd1);  // min - 1 overflows (R6)
      check("R6 min-1 ovf", W'(ov), W'(1));
      apply(corner[3], corner[3], 2'd1);  // x - x = 0 (R8)
      check("R8 equal operands", W'(nz), '0);
      apply(corner[0], corner[2], 2'd1);  // 0 - min overflows (R6)
      check("R6 0-min ovf", W'(ov), W'(1));

      // Corner pairs under every function
      for (int f = 0; f < 4; f++)
         for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
               apply(corner[i], corner[j], 2'(f));

      // Random operands
      for (int k = 0; k < 300; k++)
         for (int f = 0; f < 4; f++)
            apply($urandom(), $urandom(), 2'(f));

      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule